// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is a management master for the two-wire PHY register bus. It turns one host request into one serial frame on a clock pin and a data pin that can be tristated. The request is a read or a write of one 16-bit register, selected by a 5-bit PHY address and a 5-bit register number. The host pulses a start strobe with the request fields valid. It then waits for a one-cycle completion pulse. On a read, the captured register value is presented at that pulse.

Each frame begins with a run of 32 ones as preamble. A start pair follows, then a two-bit operation code, the PHY address and the register number. The read frame tristates the line for a single turnaround slot. It captures sixteen bits and ends with one idle clock, for 64 clocks in all. The write frame uses two tristated turnaround slots, drives sixteen data bits and ends with one idle clock, for 65 clocks. Every bit is put on the line while the management clock is low and sampled while it is high. A programmable divider sets the clock's half period in system clocks.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset and between frames, mdc_o, mdio_o and mdio_oe_o are all low, busy_o and done_o are low, and rdata_o is 0 after reset.
- R2: A frame starts with 32 bit times that each drive 1 with mdio_oe_o high.
- R3: Bit times 32 and 33 drive 0 then 1. Bit times 34 and 35 drive 1,0 for a read (write_i=0) and 0,1 for a write (write_i=1).
- R4: Bit times 36 to 40 drive the PHY address, most significant bit first. Bit times 41 to 45 drive the register number, most significant bit first.
- R5: A read tristates bit time 46 (mdio_oe_o low, mdio_o low). It captures mdio_i in bit times 47 to 62 as read data, most significant first. It tristates bit time 63, for exactly 64 MDC rising edges.
- R6: A write tristates bit times 46 and 47. It drives wdata_i in bit times 48 to 63, most significant first. It tristates bit time 64, for exactly 65 MDC rising edges.
- R7: mdio_o and mdio_oe_o change only while mdc_o is low. mdio_i is sampled on the last system clock of each MDC high phase.
- R8: Each MDC phase lasts HALF_CYCLES system clocks. The first rising edge comes HALF_CYCLES clocks after the start strobe is taken. The default of 10 gives 2.5 MHz from a 50 MHz clock.
- R9: busy_o rises on the cycle after an accepted start strobe. It stays high through the done cycle and falls on the cycle after it. A start strobe while busy_o is high has no effect on the frame in progress and starts no new frame.
- R10: done_o is a single-cycle pulse that comes 2·N·HALF_CYCLES clocks after the start is taken, where N is the frame's clock count.
- R11: rdata_o takes the captured value in the done cycle of a read. A write's done pulse leaves rdata_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken when idle |
| write_i | input | 1 | 1 = register write, 0 = register read |
| phy_addr_i | input | 5 | PHY address of the request |
| reg_addr_i | input | 5 | Register number of the request |
| wdata_i | input | 16 | Data for a write request |
| rdata_o | output | 16 | Data captured by the last read |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Frame in progress |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions assume that request fields only matter in the cycle a start strobe is taken. They also assume that a strobe raised while a frame is running may carry any field values without disturbing that frame. The stimulus tests the second point on purpose by pulsing start mid-frame with the opposite operation and a flipped address. The bench's PHY model changes mdio_i only just after an MDC rising edge. Read data must therefore come from the end of the high phase and not from the rising edge. In every slot outside the data window, the model drives 1, which acts as a pull-up. A capture window that is off by one slot then shows up in the returned value.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int AW          = 5;
    localparam int DW          = 16;
    localparam int PRE_BITS    = 32;
    localparam int ST_POS      = PRE_BITS;
    localparam int PA_POS      = ST_POS + 4;
    localparam int RA_POS      = PA_POS + AW;
    localparam int TA_POS      = RA_POS + AW;
    localparam int RD_DATA_POS = TA_POS + 1;
    localparam int WR_DATA_POS = TA_POS + 2;
    localparam int RD_LEN      = RD_DATA_POS + DW + 1;
    localparam int WR_LEN      = WR_DATA_POS + DW + 1;
    localparam int IDX_W       = $clog2(WR_LEN);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mdio_state_e;

    typedef struct packed {
        logic oe;
        logic dout;
        logic capture;
        logic last;
    } mdio_slot_t;

    typedef struct packed {
        mdio_state_e      st;
        logic [IDX_W-1:0] idx;
        logic             phase;
        logic             wr;
        logic [AW-1:0]    pa;
        logic [AW-1:0]    ra;
        logic [DW-1:0]    wd;
        logic [DW-1:0]    shreg;
        logic [DW-1:0]    rdata;
    } mdio_ctl_t;

endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
    parameter int HALF_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] TOP = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)
            cnt_d = '0;
        else if (cnt_q == TOP)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign tick_o = run_i && (cnt_q == TOP);

    // R8
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);

    // R8
    idle_cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);

endmodule

// File: rtl/mdio_bit_encoder.sv
module mdio_bit_encoder
    import mdio_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    input  logic             wr_i,
    input  logic [AW-1:0]    pa_i,
    input  logic [AW-1:0]    ra_i,
    input  logic [DW-1:0]    wd_i,
    output mdio_slot_t       slot_o
);
    localparam int HDR_W = 4 + 2 * AW;

    logic [HDR_W-1:0] hdr;

    // start pair, opcode, PHY address, register number
    assign hdr = {2'b01, ~wr_i, wr_i, pa_i, ra_i};

    always_comb begin
        slot_o = '0;
        if (idx_i < IDX_W'(PRE_BITS)) begin
            slot_o.oe   = 1'b1;
            slot_o.dout = 1'b1;
        end
        for (int b = 0; b < HDR_W; b++) begin
            if (idx_i == IDX_W'(ST_POS + b)) begin
                slot_o.oe   = 1'b1;
                slot_o.dout = hdr[HDR_W-1-b];
            end
        end
        if (wr_i) begin
            for (int b = 0; b < DW; b++) begin
                if (idx_i == IDX_W'(WR_DATA_POS + b)) begin
                    slot_o.oe   = 1'b1;
                    slot_o.dout = wd_i[DW-1-b];
                end
            end
            slot_o.last = (idx_i == IDX_W'(WR_LEN - 1));
        end else begin
            for (int b = 0; b < DW; b++) begin
                if (idx_i == IDX_W'(RD_DATA_POS + b))
                    slot_o.capture = 1'b1;
            end
            slot_o.last = (idx_i == IDX_W'(RD_LEN - 1));
        end
    end

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
    import mdio_pkg::*;
#(
    parameter int HALF_CYCLES = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        write_i,
    input  logic [4:0]  phy_addr_i,
    input  logic [4:0]  reg_addr_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] rdata_o,
    output logic        done_o,
    output logic        busy_o,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe_o,
    input  logic        mdio_i
);
    mdio_ctl_t  ctl_d, ctl_q;
    mdio_slot_t slot;
    logic       tick;
    logic       running;

    assign running = (ctl_q.st == ST_RUN);

    mdio_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running),
        .tick_o (tick)
    );

    mdio_bit_encoder u_enc (
        .idx_i  (ctl_q.idx),
        .wr_i   (ctl_q.wr),
        .pa_i   (ctl_q.pa),
        .ra_i   (ctl_q.ra),
        .wd_i   (ctl_q.wd),
        .slot_o (slot)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st    = ST_RUN;
                    ctl_d.idx   = '0;
                    ctl_d.phase = 1'b0;
                    ctl_d.wr    = write_i;
                    ctl_d.pa    = phy_addr_i;
                    ctl_d.ra    = reg_addr_i;
                    ctl_d.wd    = wdata_i;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    if (!ctl_q.phase) begin
                        ctl_d.phase = 1'b1;
                    end else begin
                        ctl_d.phase = 1'b0;
                        if (slot.capture)
                            ctl_d.shreg = {ctl_q.shreg[DW-2:0], mdio_i};
                        if (slot.last) begin
                            ctl_d.st = ST_DONE;
                            if (!ctl_q.wr)
                                ctl_d.rdata = ctl_q.shreg;
                        end else begin
                            ctl_d.idx = ctl_q.idx + 1'b1;
                        end
                    end
                end
            end
            ST_DONE: ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mdc_o     = running && ctl_q.phase;
    assign mdio_oe_o = running && slot.oe;
    assign mdio_o    = running && slot.oe && slot.dout;
    assign busy_o    = (ctl_q.st != ST_IDLE);
    assign done_o    = (ctl_q.st == ST_DONE);
    assign rdata_o   = ctl_q.rdata;

    // R1
    idle_pins_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mdc_o && !mdio_o && !mdio_oe_o));

    // R7
    drive_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdc_o |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

    // R7
    no_drive_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mdio_oe_o |-> !mdio_o);

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(ctl_q.pa) && $stable(ctl_q.ra)
                                 && $stable(ctl_q.wr) && $stable(ctl_q.wd)));

    // R9
    busy_around_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R10
    done_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!mdc_o && !mdio_oe_o));

    // R11
    rdata_only_on_read_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata_o) |-> (done_o && !ctl_q.wr));

endmodule

// File: tb/mdio_frame_master_test.sv
module mdio_frame_master_test;
    localparam int H = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        write_i = 1'b0;
    logic [4:0]  phy_addr_i = '0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        done_o, busy_o, mdc_o, mdio_o, mdio_oe_o;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    logic [1:0] rec [0:79];
    int         rise_at [0:79];

    always #10 clk = ~clk;

    mdio_frame_master #(.HALF_CYCLES(H)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
        .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .done_o(done_o), .busy_o(busy_o), .mdc_o(mdc_o),
        .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected {oe, data} per bit time, built from R2..R6
    function automatic logic [1:0] want(int k, bit wr, logic [4:0] pa,
                                        logic [4:0] ra, logic [15:0] wd);
        logic [13:0] hdr;
        hdr = {2'b01, wr ? 2'b01 : 2'b10, pa, ra};
        if (k < 32) return 2'b11;
        if (k < 46) return {1'b1, hdr[13 - (k - 32)]};
        if (wr && k >= 48 && k < 64) return {1'b1, wd[15 - (k - 48)]};
        return 2'b00;
    endfunction

    task automatic check_reset();
        chk(!mdc_o && !mdio_o && !mdio_oe_o, "R1", "pins after reset",
            {mdc_o, mdio_o, mdio_oe_o}, 0);
        chk(!busy_o && !done_o, "R1", "busy/done after reset", {busy_o, done_o}, 0);
        chk(rdata_o == 16'h0, "R1", "rdata after reset", rdata_o, 0);
    endtask

    task automatic run_frame(input bit wr, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic [15:0] pat,
                             input int glitch_j);
        int n, nrise, done_at, ndone, busy_low;
        bit stab_err, busy_gap, idle_err, prev_mdc, seq_ok;
        logic [1:0] prev_pins;
        logic [15:0] rd_before;
        n = wr ? 65 : 64;
        nrise = 0; done_at = -1; ndone = 0; busy_low = -1;
        stab_err = 0; busy_gap = 0; idle_err = 0; prev_mdc = 0; prev_pins = 2'b00;
        rd_before = rdata_o;
        @(negedge clk);
        write_i = wr; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd;
        start_i = 1'b1; mdio_i = 1'b1;
        @(posedge clk);
        for (int j = 0; j < 3000; j++) begin
            @(negedge clk);
            if (j == 0) start_i = 1'b0;
            if (j == glitch_j) begin
                start_i = 1'b1; write_i = ~wr; phy_addr_i = ~pa; reg_addr_i = ~ra;
                wdata_i = ~wd;
            end
            if (j == glitch_j + 1) begin
                start_i = 1'b0; write_i = wr; phy_addr_i = pa; reg_addr_i = ra;
                wdata_i = wd;
            end
            if (mdc_o && prev_mdc && ({mdio_oe_o, mdio_o} != prev_pins)) stab_err = 1;
            if (mdc_o && !prev_mdc && nrise < 80) begin
                rec[nrise] = {mdio_oe_o, mdio_o};
                rise_at[nrise] = j;
                if (!wr && nrise >= 47 && nrise < 63) mdio_i = pat[15 - (nrise - 47)];
                else mdio_i = 1'b1;
                nrise++;
            end
            prev_mdc = mdc_o;
            prev_pins = {mdio_oe_o, mdio_o};
            if (done_o) begin
                if (done_at < 0) done_at = j;
                ndone++;
                if (wr) chk(rdata_o == rd_before, "R11", "rdata at write done", rdata_o, rd_before);
                else chk(rdata_o == pat, "R11", "rdata at read done", rdata_o, pat);
            end
            if (!busy_o && done_at < 0) busy_gap = 1;
            if (!busy_o && done_at >= 0 && busy_low < 0) busy_low = j;
            if (busy_low >= 0 && (busy_o || mdc_o || mdio_o || mdio_oe_o)) idle_err = 1;
            if (done_at >= 0 && j > done_at + 40) break;
        end
        seq_ok = 1;
        for (int k = 0; k < 32; k++) if (rec[k] != 2'b11) seq_ok = 0;
        chk(seq_ok, "R2", "preamble", 0, 1);
        seq_ok = 1;
        for (int k = 32; k < 36; k++) if (rec[k] != want(k, wr, pa, ra, wd)) seq_ok = 0;
        chk(seq_ok, "R3", "start/opcode", {rec[32], rec[33], rec[34], rec[35]},
            {want(32, wr, pa, ra, wd), want(33, wr, pa, ra, wd),
             want(34, wr, pa, ra, wd), want(35, wr, pa, ra, wd)});
        seq_ok = 1;
        for (int k = 36; k < 46; k++) if (rec[k] != want(k, wr, pa, ra, wd)) seq_ok = 0;
        chk(seq_ok, "R4", "address fields", {pa, ra}, {pa, ra});
        seq_ok = 1;
        for (int k = 46; k < n && k < nrise; k++) if (rec[k] != want(k, wr, pa, ra, wd)) seq_ok = 0;
        if (wr) begin
            chk(seq_ok, "R6", "turnaround/data/tail", 0, 1);
            chk(nrise == 65, "R6", "write clock count", nrise, 65);
        end else begin
            chk(seq_ok, "R5", "turnaround/tail tristate", 0, 1);
            chk(nrise == 64, "R5", "read clock count", nrise, 64);
        end
        chk(rise_at[0] == H, "R8", "first rise", rise_at[0], H);
        chk(rise_at[1] - rise_at[0] == 2 * H, "R8", "mdc period", rise_at[1] - rise_at[0], 2 * H);
        chk(!stab_err, "R7", "drive change while mdc high", stab_err, 0);
        chk(done_at == 2 * n * H, "R10", "done timing", done_at, 2 * n * H);
        chk(ndone == 1, "R10", "done pulse count", ndone, 1);
        chk(!busy_gap, "R9", "busy held until done", busy_gap, 0);
        chk(busy_low == done_at + 1, "R9", "busy release", busy_low, done_at + 1);
        chk(!idle_err, "R1", "idle after frame", idle_err, 0);
    endtask

    initial begin
        #(200000 * 20);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_reset();
        run_frame(1'b0, 5'h01, 5'h02, 16'h0000, 16'hA5C3, -10);   // R5 R11 read
        run_frame(1'b1, 5'h1F, 5'h00, 16'h8001, 16'h0000, -10);   // R6 R11 write keeps rdata
        run_frame(1'b0, 5'h10, 5'h1F, 16'h0000, 16'h0000, -10);   // R5 all-zero data with pull-up tail
        run_frame(1'b0, 5'h0A, 5'h15, 16'h0000, 16'hFFFF, -10);   // R5 all-one data
        run_frame(1'b0, 5'h03, 5'h11, 16'h0000, 16'h3C5A, 200);   // R9 start while busy
        run_frame(1'b1, 5'h15, 5'h0A, 16'h7FFE, 16'h0000, 900);   // R9 start while busy, write
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule